// File: doc/BRIEF.md
# Split L1 Request Dispatcher

This block is the front end of a coherence controller for a level-one cache with separate instruction and data arrays. It looks at the head of three queues: the processor request queue, the queue of responses coming back from the shared level-two banks, and the queue of requests forwarded by those banks. For a processor request it examines the tag-presence and free-way signals that the two arrays report for the head address. From those it picks exactly one controller event and the address that goes with it, which can be a victim address. Network messages are decoded into their own events. Malformed traffic raises a fault code instead of an event.

The block is a three-state machine. `ST_IDLE` looks at the queue heads, with forwarded requests taking priority over responses and responses over processor requests. If the chosen message decodes cleanly, the block moves to `ST_ISSUE` and latches the event. It then presents that event until the controller acknowledges it, and returns to `ST_IDLE` on the acknowledge. If the message is faulty, the block moves to `ST_FAULT`, shows the fault code for one cycle, discards the message and returns to `ST_IDLE`. A source queue is popped only when its message is finished. Write-back and replacement events leave the processor request at the head, so it is evaluated again once the controller has changed the arrays.

A block found in the array that the request does not target is the split-cache special case. The dispatcher first raises a write-back on that block, and only after that does the normal access go ahead.

Top module: `l1_split_dispatch`

## Requirements
- R1: A processor request of type 1 (instruction fetch) targets the instruction array: its hit, free-way and victim inputs. Types 0 (load), 2 (store) and 3 (atomic) target the data array.
- R2: If the block is present only in the non-target array, the event is write-back (kind 4) on the request address and the request is not popped. Once that array no longer holds the block, the same request dispatches normally.
- R3: If the target array has the tag, or has a free way, the request becomes load (kind 0), fetch (kind 1) or store (kind 2). Atomic (type 3) also becomes store. The request is popped in the cycle its event is acknowledged.
- R4: If the tag is absent from both arrays and the target set is full, the event is replacement (kind 3) on the target array's victim address, and the request is not popped.
- R5: A processor request type of 4 to 7 gives fault code 1 for one cycle and the request is popped, with no event.
- R6: A block present in both arrays gives fault code 4 and the request is popped, with no event.
- R7: Response types 0, 1, 2 and 3 (data, data-then-shared, data-then-invalid, put acknowledge) give events 5, 6, 7 and 8 on the response address. Response types 4 to 7 give fault code 1.
- R8: Forwarded types 0, 1 and 2 (downgrade, invalidate-modified, invalidate-shared) give events 9, 10 and 11. Forwarded type 3 gives fault code 1.
- R9: A network message whose sender is not an L2 bank gives fault code 2; this check comes before the other two. A message not addressed to this cache gives fault code 3. In both cases the message is popped.
- R10: At most one event is presented at a time. Its kind and address stay stable until it is acknowledged, and no queue is popped before then.
- R11: When several queues are valid, forwarded requests are served before responses, and responses before processor requests.
- R12: After reset there is no event, no fault and no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor queue head valid |
| req_type | input | 3 | Processor request type |
| req_addr | input | ADDR_W | Processor request address |
| req_pop | output | 1 | Dequeue processor head |
| ic_hit | input | 1 | Instruction array holds request tag |
| dc_hit | input | 1 | Data array holds request tag |
| ic_way_free | input | 1 | Instruction array set has a free way |
| dc_way_free | input | 1 | Data array set has a free way |
| ic_victim | input | ADDR_W | Instruction array victim address |
| dc_victim | input | ADDR_W | Data array victim address |
| rsp_valid | input | 1 | Response queue head valid |
| rsp_type | input | 3 | Response type |
| rsp_from_l2 | input | 1 | Response sender is an L2 bank |
| rsp_to_me | input | 1 | Response destination includes this cache |
| rsp_addr | input | ADDR_W | Response address |
| rsp_pop | output | 1 | Dequeue response head |
| fwd_valid | input | 1 | Forwarded queue head valid |
| fwd_type | input | 2 | Forwarded request type |
| fwd_from_l2 | input | 1 | Forwarded sender is an L2 bank |
| fwd_to_me | input | 1 | Forwarded destination includes this cache |
| fwd_addr | input | ADDR_W | Forwarded address |
| fwd_pop | output | 1 | Dequeue forwarded head |
| evt_valid | output | 1 | Event presented to controller |
| evt_kind | output | 4 | Event kind |
| evt_addr | output | ADDR_W | Event address |
| evt_ack | input | 1 | Controller consumed the event |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 3 | Fault code |

## Verification
If the latched source is wrong, the pop goes to the wrong queue in the acknowledge cycle. If the victim mux is wrong, a replacement carries the other array's victim in the first cycle the event is shown. The latched state appears one clock after the queue head is chosen, so a corrupted event kind or address shows within that one cycle. A wrong state register shows up either as an event that keeps being presented after its acknowledge or as a fault pulse longer than one cycle. Both are visible on the very next clock.

// File: rtl/l1_dispatch_pkg.sv
package l1_dispatch_pkg;
    localparam logic [3:0] EV_LOAD      = 4'd0;
    localparam logic [3:0] EV_FETCH     = 4'd1;
    localparam logic [3:0] EV_STORE     = 4'd2;
    localparam logic [3:0] EV_REPLACE   = 4'd3;
    localparam logic [3:0] EV_WRBACK    = 4'd4;
    localparam logic [3:0] EV_DATA      = 4'd5;
    localparam logic [3:0] EV_DATA_SH   = 4'd6;
    localparam logic [3:0] EV_DATA_INV  = 4'd7;
    localparam logic [3:0] EV_PUT_ACK   = 4'd8;
    localparam logic [3:0] EV_DOWNGRADE = 4'd9;
    localparam logic [3:0] EV_INV_MOD   = 4'd10;
    localparam logic [3:0] EV_INV_SH    = 4'd11;

    localparam logic [2:0] FLT_NONE   = 3'd0;
    localparam logic [2:0] FLT_TYPE   = 3'd1;
    localparam logic [2:0] FLT_SENDER = 3'd2;
    localparam logic [2:0] FLT_DEST   = 3'd3;
    localparam logic [2:0] FLT_DUAL   = 3'd4;

    typedef enum logic [1:0] {SRC_PROC, SRC_RSP, SRC_FWD} src_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_FAULT} disp_state_e;
endpackage

// File: rtl/l1_proc_decode.sv
module l1_proc_decode
    import l1_dispatch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ic_hit,
    input  logic              dc_hit,
    input  logic              ic_way_free,
    input  logic              dc_way_free,
    input  logic [ADDR_W-1:0] ic_victim,
    input  logic [ADDR_W-1:0] dc_victim,
    output logic [3:0]        kind,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [2:0]        fcode
);
    logic to_icache, hit_tgt, hit_other, free_tgt;
    logic [ADDR_W-1:0] victim_tgt;

    always_comb begin
        to_icache  = (req_type == 3'd1);
        hit_tgt    = to_icache ? ic_hit : dc_hit;
        hit_other  = to_icache ? dc_hit : ic_hit;
        free_tgt   = to_icache ? ic_way_free : dc_way_free;
        victim_tgt = to_icache ? ic_victim : dc_victim;
        kind  = EV_LOAD;
        addr  = req_addr;
        done  = 1'b0;
        fcode = FLT_NONE;
        if (req_type[2]) begin
            fcode = FLT_TYPE;
        end else if (ic_hit && dc_hit) begin
            fcode = FLT_DUAL;
        end else if (hit_other) begin
            kind = EV_WRBACK;
        end else if (hit_tgt || free_tgt) begin
            done = 1'b1;
            unique case (req_type[1:0])
                2'd0:    kind = EV_LOAD;
                2'd1:    kind = EV_FETCH;
                default: kind = EV_STORE;
            endcase
        end else begin
            kind = EV_REPLACE;
            addr = victim_tgt;
        end
    end
endmodule

// File: rtl/l1_net_decode.sv
module l1_net_decode
    import l1_dispatch_pkg::*;
#(
    parameter bit FORWARDED = 1'b0
) (
    input  logic [2:0] msg_type,
    input  logic       from_l2,
    input  logic       to_me,
    output logic [3:0] kind,
    output logic [2:0] fcode
);
    logic [3:0] kind_raw;
    logic       type_bad;

    generate
        if (FORWARDED) begin : g_fwd
            always_comb begin
                type_bad = (msg_type[1:0] == 2'd3) || msg_type[2];
                unique case (msg_type[1:0])
                    2'd0:    kind_raw = EV_DOWNGRADE;
                    2'd1:    kind_raw = EV_INV_MOD;
                    default: kind_raw = EV_INV_SH;
                endcase
            end
        end else begin : g_rsp
            always_comb begin
                type_bad = msg_type[2];
                unique case (msg_type[1:0])
                    2'd0:    kind_raw = EV_DATA;
                    2'd1:    kind_raw = EV_DATA_SH;
                    2'd2:    kind_raw = EV_DATA_INV;
                    default: kind_raw = EV_PUT_ACK;
                endcase
            end
        end
    endgenerate

    always_comb begin
        kind = kind_raw;
        if (!from_l2)      fcode = FLT_SENDER;
        else if (!to_me)   fcode = FLT_DEST;
        else if (type_bad) fcode = FLT_TYPE;
        else               fcode = FLT_NONE;
    end
endmodule

// File: rtl/l1_split_dispatch.sv
module l1_split_dispatch
    import l1_dispatch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_pop,
    input  logic              ic_hit,
    input  logic              dc_hit,
    input  logic              ic_way_free,
    input  logic              dc_way_free,
    input  logic [ADDR_W-1:0] ic_victim,
    input  logic [ADDR_W-1:0] dc_victim,
    input  logic              rsp_valid,
    input  logic [2:0]        rsp_type,
    input  logic              rsp_from_l2,
    input  logic              rsp_to_me,
    input  logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_pop,
    input  logic              fwd_valid,
    input  logic [1:0]        fwd_type,
    input  logic              fwd_from_l2,
    input  logic              fwd_to_me,
    input  logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_pop,
    output logic              evt_valid,
    output logic [3:0]        evt_kind,
    output logic [ADDR_W-1:0] evt_addr,
    input  logic              evt_ack,
    output logic              fault_valid,
    output logic [2:0]        fault_code
);
    logic [3:0]        p_kind, r_kind, f_kind;
    logic [ADDR_W-1:0] p_addr;
    logic              p_done;
    logic [2:0]        p_fc, r_fc, f_fc;

    l1_proc_decode #(.ADDR_W(ADDR_W)) u_proc (
        .req_type(req_type), .req_addr(req_addr),
        .ic_hit(ic_hit), .dc_hit(dc_hit),
        .ic_way_free(ic_way_free), .dc_way_free(dc_way_free),
        .ic_victim(ic_victim), .dc_victim(dc_victim),
        .kind(p_kind), .addr(p_addr), .done(p_done), .fcode(p_fc)
    );

    l1_net_decode #(.FORWARDED(1'b0)) u_rsp (
        .msg_type(rsp_type), .from_l2(rsp_from_l2), .to_me(rsp_to_me),
        .kind(r_kind), .fcode(r_fc)
    );

    l1_net_decode #(.FORWARDED(1'b1)) u_fwd (
        .msg_type({1'b0, fwd_type}), .from_l2(fwd_from_l2), .to_me(fwd_to_me),
        .kind(f_kind), .fcode(f_fc)
    );

    disp_state_e       state_q, state_d;
    src_e              src_q, src_d;
    logic [3:0]        kind_q, kind_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              done_q, done_d;
    logic [2:0]        fc_q, fc_d;
    logic              any_valid;

    // head selection: forwarded, then response, then processor
    always_comb begin
        any_valid = fwd_valid || rsp_valid || req_valid;
        src_d  = SRC_PROC;
        kind_d = p_kind;
        addr_d = p_addr;
        done_d = p_done;
        fc_d   = p_fc;
        if (fwd_valid) begin
            src_d = SRC_FWD; kind_d = f_kind; addr_d = fwd_addr;
            done_d = 1'b1;   fc_d = f_fc;
        end else if (rsp_valid) begin
            src_d = SRC_RSP; kind_d = r_kind; addr_d = rsp_addr;
            done_d = 1'b1;   fc_d = r_fc;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_valid) state_d = (fc_d != FLT_NONE) ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: if (evt_ack)   state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_PROC;
            kind_q  <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            fc_q    <= FLT_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any_valid) begin
                src_q  <= src_d;
                kind_q <= kind_d;
                addr_q <= addr_d;
                done_q <= done_d;
                fc_q   <= fc_d;
            end
        end
    end

    logic finish;
    always_comb begin
        evt_valid   = 1'b0;
        fault_valid = 1'b0;
        fault_code  = FLT_NONE;
        finish      = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                evt_valid = 1'b1;
                finish    = evt_ack && done_q;
            end
            ST_FAULT: begin
                fault_valid = 1'b1;
                fault_code  = fc_q;
                finish      = 1'b1;
            end
            default: ;
        endcase
        evt_kind = kind_q;
        evt_addr = addr_q;
        req_pop  = finish && (src_q == SRC_PROC);
        rsp_pop  = finish && (src_q == SRC_RSP);
        fwd_pop  = finish && (src_q == SRC_FWD);
    end
endmodule

// File: rtl/l1_split_dispatch_chk.sv
module l1_split_dispatch_chk
    import l1_dispatch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_pop,
    input logic              rsp_pop,
    input logic              fwd_pop,
    input logic              evt_valid,
    input logic [3:0]        evt_kind,
    input logic [ADDR_W-1:0] evt_addr,
    input logic              evt_ack,
    input logic              fault_valid
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ack |=> evt_valid && $stable(evt_kind) && $stable(evt_addr));

    p_one_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_pop, rsp_pop, fwd_pop}) <= 1);

    p_pop_needs_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pop || rsp_pop || fwd_pop) && !fault_valid |-> evt_valid && evt_ack);

    p_no_pop_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && (evt_kind == EV_WRBACK) |-> !req_pop);

    p_no_pop_repl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && (evt_kind == EV_REPLACE) |-> !req_pop);

    p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    p_fault_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !evt_valid);
endmodule

bind l1_split_dispatch l1_split_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_pop(req_pop), .rsp_pop(rsp_pop),
    .fwd_pop(fwd_pop), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_addr(evt_addr), .evt_ack(evt_ack), .fault_valid(fault_valid)
);

// File: tb/test_l1_split_dispatch.sv
module test_l1_split_dispatch;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0; logic [2:0] req_type = 0; logic [AW-1:0] req_addr = 0;
    logic ic_hit = 0, dc_hit = 0, ic_way_free = 1, dc_way_free = 1;
    logic [AW-1:0] ic_victim = 32'h1111_0000, dc_victim = 32'h2222_0000;
    logic rsp_valid = 0; logic [2:0] rsp_type = 0; logic rsp_from_l2 = 1, rsp_to_me = 1;
    logic [AW-1:0] rsp_addr = 0;
    logic fwd_valid = 0; logic [1:0] fwd_type = 0; logic fwd_from_l2 = 1, fwd_to_me = 1;
    logic [AW-1:0] fwd_addr = 0;
    logic evt_ack = 0;
    logic req_pop, rsp_pop, fwd_pop, evt_valid, fault_valid;
    logic [3:0] evt_kind; logic [AW-1:0] evt_addr; logic [2:0] fault_code;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    l1_split_dispatch #(.ADDR_W(AW)) i_l1_split_dispatch (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_pop(req_pop),
        .ic_hit(ic_hit), .dc_hit(dc_hit), .ic_way_free(ic_way_free), .dc_way_free(dc_way_free),
        .ic_victim(ic_victim), .dc_victim(dc_victim),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_from_l2(rsp_from_l2),
        .rsp_to_me(rsp_to_me), .rsp_addr(rsp_addr), .rsp_pop(rsp_pop),
        .fwd_valid(fwd_valid), .fwd_type(fwd_type), .fwd_from_l2(fwd_from_l2),
        .fwd_to_me(fwd_to_me), .fwd_addr(fwd_addr), .fwd_pop(fwd_pop),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_addr(evt_addr), .evt_ack(evt_ack),
        .fault_valid(fault_valid), .fault_code(fault_code)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // pops are {fwd,rsp,req}
    task automatic expect_event(input string req, input logic [3:0] k, input logic [AW-1:0] a,
                                input logic [2:0] pops);
        @(posedge clk); @(negedge clk);
        check({req, " valid"}, evt_valid, 1);
        check({req, " kind"}, evt_kind, k);
        check({req, " addr"}, evt_addr, a);
        check({req, " early pop"}, {fwd_pop, rsp_pop, req_pop}, 0);
        evt_ack = 1;
        #1;
        check({req, " pop"}, {fwd_pop, rsp_pop, req_pop}, pops);
        @(posedge clk); @(negedge clk);
        evt_ack = 0;
        check({req, " released"}, evt_valid, 0);
    endtask

    task automatic expect_fault(input string req, input logic [2:0] code, input logic [2:0] pops);
        @(posedge clk); @(negedge clk);
        check({req, " fault"}, fault_valid, 1);
        check({req, " code"}, fault_code, code);
        check({req, " no event"}, evt_valid, 0);
        check({req, " pop"}, {fwd_pop, rsp_pop, req_pop}, pops);
        @(posedge clk); @(negedge clk);
        check({req, " pulse"}, fault_valid, 0);
    endtask

    task automatic t_reset();
        check("R12 evt", evt_valid, 0);
        check("R12 fault", fault_valid, 0);
        check("R12 pops", {fwd_pop, rsp_pop, req_pop}, 0);
    endtask

    task automatic t_normal();
        req_valid = 1; req_type = 0; req_addr = 32'hA000_0040;
        expect_event("R3 load free way", 4'd0, 32'hA000_0040, 3'b001);
        req_type = 1; ic_hit = 1; ic_way_free = 0; req_addr = 32'hB000_0080;
        expect_event("R3 fetch hit", 4'd1, 32'hB000_0080, 3'b001);
        ic_hit = 0; ic_way_free = 1; dc_hit = 1; dc_way_free = 0; req_type = 2;
        expect_event("R3 store hit", 4'd2, 32'hB000_0080, 3'b001);
        req_type = 3;
        expect_event("R3 atomic as store", 4'd2, 32'hB000_0080, 3'b001);
        dc_hit = 0; dc_way_free = 1; req_valid = 0;
    endtask

    task automatic t_wrong_array();
        req_valid = 1; req_type = 1; req_addr = 32'hC000_0100; dc_hit = 1;
        expect_event("R2 fetch in dcache", 4'd4, 32'hC000_0100, 3'b000);
        dc_hit = 0;
        expect_event("R2 then fetch", 4'd1, 32'hC000_0100, 3'b001);
        req_type = 0; ic_hit = 1;
        expect_event("R2 load in icache", 4'd4, 32'hC000_0100, 3'b000);
        ic_hit = 0; req_valid = 0;
    endtask

    task automatic t_replace();
        req_valid = 1; req_type = 0; req_addr = 32'hD000_0000; dc_way_free = 0;
        expect_event("R4 data replace", 4'd3, 32'h2222_0000, 3'b000);
        req_type = 1;
        expect_event("R1 fetch uses icache free", 4'd1, 32'hD000_0000, 3'b001);
        dc_way_free = 1; ic_way_free = 0;
        expect_event("R4 fetch replace", 4'd3, 32'h1111_0000, 3'b000);
        req_type = 2;
        expect_event("R1 store uses dcache free", 4'd2, 32'hD000_0000, 3'b001);
        ic_way_free = 1; req_valid = 0;
    endtask

    task automatic t_req_faults();
        req_valid = 1; req_type = 5;
        expect_fault("R5 unknown type", 3'd1, 3'b001);
        req_type = 0; ic_hit = 1; dc_hit = 1;
        expect_fault("R6 dual presence", 3'd4, 3'b001);
        ic_hit = 0; dc_hit = 0; req_valid = 0;
    endtask

    task automatic t_responses();
        rsp_valid = 1; rsp_addr = 32'hE000_0000;
        for (int t = 0; t < 4; t++) begin
            rsp_type = 3'(t);
            expect_event("R7 response", 4'(5 + t), 32'hE000_0000, 3'b010);
        end
        rsp_type = 6;
        expect_fault("R7 bad response", 3'd1, 3'b010);
        rsp_valid = 0;
    endtask

    task automatic t_forwarded();
        fwd_valid = 1; fwd_addr = 32'hF000_0000;
        for (int t = 0; t < 3; t++) begin
            fwd_type = 2'(t);
            expect_event("R8 forwarded", 4'(9 + t), 32'hF000_0000, 3'b100);
        end
        fwd_type = 3;
        expect_fault("R8 bad forwarded", 3'd1, 3'b100);
        fwd_valid = 0;
    endtask

    task automatic t_origin();
        rsp_valid = 1; rsp_type = 0; rsp_from_l2 = 0;
        expect_fault("R9 response sender", 3'd2, 3'b010);
        rsp_to_me = 0; rsp_type = 6;
        expect_fault("R9 sender precedence", 3'd2, 3'b010);
        rsp_valid = 0; rsp_from_l2 = 1; rsp_to_me = 1;
        fwd_valid = 1; fwd_type = 1; fwd_to_me = 0;
        expect_fault("R9 forwarded destination", 3'd3, 3'b100);
        fwd_valid = 0; fwd_to_me = 1;
    endtask

    task automatic t_hold();
        req_valid = 1; req_type = 0; req_addr = 32'h1234_5670;
        @(posedge clk); @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            req_addr = 32'h0; dc_way_free = 0; req_type = 1;
            check("R10 held valid", evt_valid, 1);
            check("R10 held kind", evt_kind, 4'd0);
            check("R10 held addr", evt_addr, 32'h1234_5670);
            check("R10 no pop", {fwd_pop, rsp_pop, req_pop}, 0);
            @(posedge clk); @(negedge clk);
        end
        evt_ack = 1; #1;
        check("R10 pop on ack", req_pop, 1);
        @(posedge clk); @(negedge clk);
        evt_ack = 0; req_valid = 0; dc_way_free = 1;
    endtask

    task automatic t_priority();
        req_valid = 1; req_type = 0; req_addr = 32'h100;
        rsp_valid = 1; rsp_type = 0; rsp_addr = 32'h200;
        fwd_valid = 1; fwd_type = 2; fwd_addr = 32'h300;
        expect_event("R11 forwarded first", 4'd11, 32'h300, 3'b100);
        fwd_valid = 0;
        expect_event("R11 response second", 4'd5, 32'h200, 3'b010);
        rsp_valid = 0;
        expect_event("R11 processor last", 4'd0, 32'h100, 3'b001);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_wrong_array();
        t_replace();
        t_req_faults();
        t_responses();
        t_forwarded();
        t_origin();
        t_hold();
        t_priority();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule